// File: doc/BRIEF.md
# Duplicate-Execution Fault Checker With Spare Voter

Each processing cell holds its own primary gene and a secondary copy of one neighbour's gene. This checker re-executes that copied gene when its start token arrives and keeps the local result. Later the neighbour's result package arrives with the primary start token, and the checker compares the two values. If they agree, the sample is good and the checker returns to idle.

If they disagree, the checker sends a one-cycle test request to the nearest spare cell. The request carries the gene's opcode and operands. The spare re-runs the gene and returns a third result, which acts as the deciding vote. A result that disagrees with the other two marks its cell as faulty. When all three results differ, the fault is unresolved. If no vote arrives within a programmable number of cycles, the checker reports a timeout. Every verdict also raises a discard strobe so the affected data sample is dropped.

Top module: `dup_exec_checker`

## Requirements
- R1: After reset, test_req, fault_flag, unresolved_flag, timeout_flag and discard are 0, and fault_id is 0.
- R2: A secondary start token taken while idle captures the opcode, operands and owner id. The local result is computed from them with this opcode encoding: 0 = a+b, 1 = a-b, 2 = a XOR b, 3 = a AND b, all modulo 2^32. A secondary start token taken while the checker is busy has no effect.
- R3: The checker accepts a primary start token only after the local result is ready, and only when pri_src equals the stored owner id. Any other primary token is ignored, including one that arrives while idle.
- R4: The checker samples the primary result package on the edge that accepts the primary token. In the cycle after that edge, test_req is high for exactly one cycle if the package result differs from the local result. During that cycle, test_dst equals spare_id and test_op, test_a and test_b carry the stored gene. If the two results match, no request and no flag follow.
- R5: If the vote equals the local result and differs from the package result, then in the cycle after the vote is sampled, fault_flag is 1 and fault_id is the owner id.
- R6: If the vote equals the package result and differs from the local result, then in the cycle after the vote is sampled, fault_flag is 1 and fault_id is my_id.
- R7: If the vote differs from both results, then in the cycle after the vote is sampled, unresolved_flag is 1 and fault_flag is 0.
- R8: A vote is accepted during the first L cycles after the request cycle, where L = timeout_lim, and a value of 0 acts as 1. If no vote arrives in that window, timeout_flag is 1 in cycle L+1 after the request cycle.
- R9: Every verdict flag lasts one cycle and is accompanied by discard. At most one verdict flag is high at a time. A vote_valid pulse outside the vote window has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 8 | Identifier of this cell |
| spare_id | input | 8 | Identifier of the nearest spare cell |
| timeout_lim | input | 16 | Vote window length in cycles (0 acts as 1) |
| sec_start | input | 1 | Start token for the copied (secondary) gene |
| sec_op | input | 2 | Opcode of the copied gene |
| sec_a | input | 32 | Operand A of the copied gene |
| sec_b | input | 32 | Operand B of the copied gene |
| sec_owner | input | 8 | Identifier of the cell that owns the copied gene |
| pri_start | input | 1 | Start token carrying a result package |
| pri_result | input | 32 | Result carried by the package |
| pri_src | input | 8 | Sender of the package |
| vote_valid | input | 1 | Spare cell's vote is present |
| vote_result | input | 32 | Spare cell's result |
| test_req | output | 1 | One-cycle request for a test package to the spare cell |
| test_dst | output | 8 | Destination of the test package |
| test_op | output | 2 | Opcode sent with the test package |
| test_a | output | 32 | Operand A sent with the test package |
| test_b | output | 32 | Operand B sent with the test package |
| fault_flag | output | 1 | Resolved fault, one cycle |
| fault_id | output | 8 | Faulty cell while fault_flag is high, else 0 |
| unresolved_flag | output | 1 | All three results differ, one cycle |
| timeout_flag | output | 1 | Spare did not answer in time, one cycle |
| discard | output | 1 | Drop the current data sample, one cycle |

## Verification
The bench uses the default widths: 32-bit results, 8-bit identifiers and a 16-bit window count. With full-width random operands, wrap-around in add and subtract is exercised. The timeout_lim port is driven to 1, 5 and 12, which places the first and last accepted vote cycles and the timeout cycle within a few clocks of the request. The directed cases cover the ignored tokens and votes and the split vote; the random cases mix agreement, both fault directions, split votes and timeouts.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COMPUTE, ST_WAIT_PRI, ST_COMPARE, ST_WAIT_VOTE, ST_REPORT
  } chk_state_e;

  typedef enum logic [1:0] {
    GENE_ADD = 2'd0, GENE_SUB = 2'd1, GENE_XOR = 2'd2, GENE_AND = 2'd3
  } gene_op_e;

  typedef enum logic [2:0] {
    VERD_NONE, VERD_REMOTE_BAD, VERD_LOCAL_BAD, VERD_SPLIT, VERD_TIMEOUT
  } verdict_e;
endpackage

// File: rtl/dxc_gene_exec.sv
module dxc_gene_exec import dxc_pkg::*; #(
  parameter int RES_W = 32,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             calc,
  input  logic [1:0]       op_i,
  input  logic [RES_W-1:0] a_i,
  input  logic [RES_W-1:0] b_i,
  input  logic [ID_W-1:0]  owner_i,
  output logic [1:0]       op_o,
  output logic [RES_W-1:0] a_o,
  output logic [RES_W-1:0] b_o,
  output logic [ID_W-1:0]  owner_o,
  output logic [RES_W-1:0] res_o
);
  gene_op_e         op_q;
  logic [RES_W-1:0] a_q, b_q, res_q;
  logic [ID_W-1:0]  owner_q;

  function automatic logic [RES_W-1:0] gene_eval(gene_op_e op,
                                                  logic [RES_W-1:0] a,
                                                  logic [RES_W-1:0] b);
    case (op)
      GENE_ADD: return a + b;
      GENE_SUB: return a - b;
      GENE_XOR: return a ^ b;
      default:  return a & b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= GENE_ADD;
      a_q     <= '0;
      b_q     <= '0;
      owner_q <= '0;
      res_q   <= '0;
    end else begin
      if (load) begin
        op_q    <= gene_op_e'(op_i);
        a_q     <= a_i;
        b_q     <= b_i;
        owner_q <= owner_i;
      end
      if (calc) res_q <= gene_eval(op_q, a_q, b_q);
    end
  end

  assign op_o    = op_q;
  assign a_o     = a_q;
  assign b_o     = b_q;
  assign owner_o = owner_q;
  assign res_o   = res_q;

  // R2
  calc_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    calc |-> $past(load));
endmodule

// File: rtl/dxc_vote_timer.sv
module dxc_vote_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam int CW = TMO_W + 1;
  logic [TMO_W-1:0] cnt;
  logic [CW-1:0]    next_cnt;

  assign next_cnt = {1'b0, cnt} + CW'(1);
  assign expired  = run && (next_cnt >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + TMO_W'(1);
  end

  // R8
  timer_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> !run);
endmodule

// File: rtl/dxc_voter.sv
module dxc_voter import dxc_pkg::*; #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             timed_out,
  input  logic [RES_W-1:0] local_res,
  input  logic [RES_W-1:0] remote_res,
  input  logic [RES_W-1:0] vote_res,
  output verdict_e         verdict_o
);
  verdict_e verdict_q;

  function automatic verdict_e classify(logic [RES_W-1:0] loc,
                                        logic [RES_W-1:0] rem,
                                        logic [RES_W-1:0] vot);
    if (vot == loc && vot != rem) return VERD_REMOTE_BAD;
    if (vot == rem && vot != loc) return VERD_LOCAL_BAD;
    return VERD_SPLIT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       verdict_q <= VERD_NONE;
    else if (capture) verdict_q <= timed_out ? VERD_TIMEOUT
                                             : classify(local_res, remote_res, vote_res);
  end

  assign verdict_o = verdict_q;

  // R7
  split_on_disagree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !timed_out && vote_res != local_res && vote_res != remote_res)
      |=> verdict_q == VERD_SPLIT);
endmodule

// File: rtl/dup_exec_checker.sv
module dup_exec_checker import dxc_pkg::*; #(
  parameter int RES_W = 32,
  parameter int ID_W  = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  my_id,
  input  logic [ID_W-1:0]  spare_id,
  input  logic [TMO_W-1:0] timeout_lim,
  input  logic             sec_start,
  input  logic [1:0]       sec_op,
  input  logic [RES_W-1:0] sec_a,
  input  logic [RES_W-1:0] sec_b,
  input  logic [ID_W-1:0]  sec_owner,
  input  logic             pri_start,
  input  logic [RES_W-1:0] pri_result,
  input  logic [ID_W-1:0]  pri_src,
  input  logic             vote_valid,
  input  logic [RES_W-1:0] vote_result,
  output logic             test_req,
  output logic [ID_W-1:0]  test_dst,
  output logic [1:0]       test_op,
  output logic [RES_W-1:0] test_a,
  output logic [RES_W-1:0] test_b,
  output logic             fault_flag,
  output logic [ID_W-1:0]  fault_id,
  output logic             unresolved_flag,
  output logic             timeout_flag,
  output logic             discard
);
  chk_state_e       state, state_nx;
  logic [RES_W-1:0] local_res, remote_q;
  logic [ID_W-1:0]  owner_q;
  logic             load, calc, pri_hit, mismatch, win_run, win_expired;
  logic             capture, in_report;
  verdict_e         verdict;

  // named internal events
  assign load     = (state == ST_IDLE) && sec_start;
  assign calc     = (state == ST_COMPUTE);
  assign pri_hit  = (state == ST_WAIT_PRI) && pri_start && (pri_src == owner_q);
  assign mismatch = (remote_q != local_res);
  assign win_run  = (state == ST_WAIT_VOTE);
  assign capture  = win_run && (vote_valid || win_expired);
  assign in_report = (state == ST_REPORT);

  dxc_gene_exec #(.RES_W(RES_W), .ID_W(ID_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .load(load), .calc(calc),
    .op_i(sec_op), .a_i(sec_a), .b_i(sec_b), .owner_i(sec_owner),
    .op_o(test_op), .a_o(test_a), .b_o(test_b), .owner_o(owner_q),
    .res_o(local_res));

  dxc_vote_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(win_run), .limit(timeout_lim),
    .expired(win_expired));

  dxc_voter #(.RES_W(RES_W)) u_voter (
    .clk(clk), .rst_n(rst_n), .capture(capture), .timed_out(!vote_valid),
    .local_res(local_res), .remote_res(remote_q), .vote_res(vote_result),
    .verdict_o(verdict));

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:      if (load) state_nx = ST_COMPUTE;
      ST_COMPUTE:   state_nx = ST_WAIT_PRI;
      ST_WAIT_PRI:  if (pri_hit) state_nx = ST_COMPARE;
      ST_COMPARE:   state_nx = mismatch ? ST_WAIT_VOTE : ST_IDLE;
      ST_WAIT_VOTE: if (capture) state_nx = ST_REPORT;
      default:      state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remote_q <= '0;
    end else begin
      state <= state_nx;
      if (pri_hit) remote_q <= pri_result;
    end
  end

  assign test_req        = (state == ST_COMPARE) && mismatch;
  assign test_dst        = spare_id;
  assign fault_flag      = in_report && (verdict == VERD_REMOTE_BAD || verdict == VERD_LOCAL_BAD);
  assign unresolved_flag = in_report && (verdict == VERD_SPLIT);
  assign timeout_flag    = in_report && (verdict == VERD_TIMEOUT);
  assign discard         = in_report;

  always_comb begin
    fault_id = '0;
    if (in_report && verdict == VERD_REMOTE_BAD) fault_id = owner_q;
    if (in_report && verdict == VERD_LOCAL_BAD)  fault_id = my_id;
  end

  // R2
  compute_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPUTE) |-> $past(state == ST_IDLE && sec_start));
  // R3
  compare_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMPARE) |-> ($past(state == ST_WAIT_PRI) && $past(pri_src) == owner_q));
  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |=> !test_req);
  // R5 R6
  fault_id_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |-> (fault_id == my_id || fault_id == owner_q));
  // R8
  timeout_novote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |-> !$past(vote_valid));
  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_flag, unresolved_flag, timeout_flag}));
  // R9
  discard_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> ($past(state) == ST_WAIT_VOTE) && !$past(discard));
endmodule

// File: tb/test_dup_exec_checker.sv
module test_dup_exec_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  my_id = 8'h21, spare_id = 8'h5C;
  logic [15:0] timeout_lim = 16'd5;
  logic        sec_start = 1'b0, pri_start = 1'b0, vote_valid = 1'b0;
  logic [1:0]  sec_op = 2'd0;
  logic [31:0] sec_a = '0, sec_b = '0, pri_result = '0, vote_result = '0;
  logic [7:0]  sec_owner = '0, pri_src = '0;
  logic        test_req, fault_flag, unresolved_flag, timeout_flag, discard;
  logic [7:0]  test_dst, fault_id;
  logic [1:0]  test_op;
  logic [31:0] test_a, test_b;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dup_exec_checker i_dup_exec_checker (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_gene(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    if (op == 2'd0) return a + b;
    if (op == 2'd1) return a + ~b + 32'd1;
    if (op == 2'd2) return (a | b) & ~(a & b);
    return ~(~a | ~b);
  endfunction

  task automatic quiet_chk(input string tag);
    chk({test_req, fault_flag, unresolved_flag, timeout_flag, discard} == 5'b0, tag,
        {test_req, fault_flag, unresolved_flag, timeout_flag, discard}, 0);
  endtask

  // mode 1: vote given after 'delay' cycles; mode 0: no vote
  task automatic run_case(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [7:0] owner, input logic [31:0] remote,
                          input int mode, input logic [31:0] vote, input int delay);
    logic [31:0] loc = ref_gene(op, a, b);
    bit mis = (remote != loc);
    int lim = (timeout_lim == 0) ? 1 : int'(timeout_lim);
    @(negedge clk); sec_start = 1; sec_op = op; sec_a = a; sec_b = b; sec_owner = owner;
    @(negedge clk); sec_start = 0;
    @(negedge clk); pri_start = 1; pri_result = remote; pri_src = owner;
    @(negedge clk); pri_start = 0;
    chk(test_req == mis, "R4 test_req", test_req, mis);
    if (mis) begin
      chk(test_dst == spare_id, "R4 test_dst", test_dst, spare_id);
      chk({test_op, test_a, test_b} == {op, a, b}, "R2 R4 test payload", test_a, a);
    end
    @(negedge clk);
    if (!mis) begin
      quiet_chk("R4 match gives no verdict");
      return;
    end
    if (mode == 1) begin
      bit al = (vote == loc), ar = (vote == remote);
      repeat (delay) @(negedge clk);
      vote_valid = 1; vote_result = vote;
      @(negedge clk); vote_valid = 0;
      chk(discard == 1, "R9 discard", discard, 1);
      if (al && !ar) begin
        chk(fault_flag && !unresolved_flag, "R5 fault flag", fault_flag, 1);
        chk(fault_id == owner, "R5 fault_id owner", fault_id, owner);
      end else if (ar && !al) begin
        chk(fault_flag && !unresolved_flag, "R6 fault flag", fault_flag, 1);
        chk(fault_id == my_id, "R6 fault_id self", fault_id, my_id);
      end else begin
        chk(unresolved_flag && !fault_flag, "R7 unresolved", unresolved_flag, 1);
      end
      chk(!timeout_flag, "R8 no timeout with vote", timeout_flag, 0);
    end else begin
      if (lim > 1) begin
        repeat (lim - 1) @(negedge clk);
        chk(!timeout_flag, "R8 early timeout", timeout_flag, 0);
      end
      @(negedge clk);
      chk(timeout_flag && discard && !fault_flag, "R8 timeout", timeout_flag, 1);
    end
    @(negedge clk);
    quiet_chk("R9 one-cycle verdict");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    quiet_chk("R1 reset outputs");
    chk(fault_id == 0, "R1 fault_id", fault_id, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: primary token while idle is ignored
    pri_start = 1; pri_result = 32'hDEAD; pri_src = 8'h90;
    @(negedge clk); pri_start = 0;
    quiet_chk("R3 primary in idle ignored");
    @(negedge clk); quiet_chk("R3 primary in idle ignored later");

    // R9: vote outside window ignored
    vote_valid = 1; vote_result = 32'h1;
    @(negedge clk); vote_valid = 0;
    quiet_chk("R9 stray vote ignored");
    @(negedge clk); quiet_chk("R9 stray vote ignored later");

    // R2 busy secondary ignored, R3 wrong source ignored
    sec_start = 1; sec_op = 2'd0; sec_a = 32'd10; sec_b = 32'd5; sec_owner = 8'h90;
    @(negedge clk); sec_start = 0;
    @(negedge clk);
    sec_start = 1; sec_op = 2'd3; sec_a = 32'hFF; sec_b = 32'h0F; sec_owner = 8'h91;
    @(negedge clk); sec_start = 0;
    pri_start = 1; pri_result = 32'd99; pri_src = 8'h91;
    @(negedge clk); pri_start = 0;
    chk(!test_req, "R3 wrong source ignored", test_req, 0);
    pri_start = 1; pri_result = 32'd16; pri_src = 8'h90;
    @(negedge clk); pri_start = 0;
    chk(test_req == 1, "R4 mismatch request", test_req, 1);
    chk(test_a == 32'd10 && test_op == 2'd0, "R2 busy secondary ignored", test_a, 10);
    @(negedge clk);
    vote_valid = 1; vote_result = 32'd15;
    @(negedge clk); vote_valid = 0;
    chk(fault_flag && fault_id == 8'h90, "R5 directed remote fault", fault_id, 8'h90);
    @(negedge clk);

    // directed corners
    run_case(2'd1, 32'd0, 32'd1, 8'h90, 32'hFFFFFFFF, 1, 32'd0, 0);       // match, borrow wrap
    run_case(2'd0, 32'hFFFFFFFF, 32'd2, 8'h92, 32'd7, 1, 32'd7, 4);       // R6, last window cycle
    run_case(2'd2, 32'hF0F0, 32'h0FF0, 8'h93, 32'd1, 1, 32'd2, 0);        // R7 split
    run_case(2'd3, 32'hF0F0, 32'h0FF0, 8'h94, 32'd3, 0, 32'd0, 0);        // R8 lim 5
    timeout_lim = 16'd1;
    run_case(2'd0, 32'd1, 32'd1, 8'h95, 32'd3, 0, 32'd0, 0);              // R8 lim 1
    run_case(2'd0, 32'd1, 32'd1, 8'h95, 32'd3, 1, 32'd2, 0);              // R5 lim 1
    timeout_lim = 16'd0;
    run_case(2'd0, 32'd4, 32'd4, 8'h96, 32'd3, 0, 32'd0, 0);              // R8 zero acts as one
    timeout_lim = 16'd12;
    run_case(2'd1, 32'd9, 32'd4, 8'h97, 32'd6, 0, 32'd0, 0);              // R8 lim 12
    run_case(2'd1, 32'd9, 32'd4, 8'h97, 32'd6, 1, 32'd5, 11);             // R5 lim 12 edge
    timeout_lim = 16'd5;

    for (int i = 0; i < 60; i++) begin
      logic [1:0]  op = 2'($urandom);
      logic [31:0] a = $urandom, b = $urandom;
      logic [31:0] loc = ref_gene(op, a, b);
      logic [31:0] m1 = {31'($urandom), 1'b1};
      logic [31:0] m2 = {31'($urandom), 1'b0} | 32'd2;
      logic [7:0]  own = {1'b1, 7'($urandom)};
      int sel = int'($urandom % 5);
      int dly = int'($urandom % 5);
      case (sel)
        0: run_case(op, a, b, own, loc, 1, 32'd0, 0);
        1: run_case(op, a, b, own, loc ^ m1, 1, loc, dly);
        2: run_case(op, a, b, own, loc ^ m1, 1, loc ^ m1, dly);
        3: run_case(op, a, b, own, loc ^ m1, 1, loc ^ m2, dly);
        default: run_case(op, a, b, own, loc ^ m1, 0, 32'd0, 0);
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule